// File: doc/BRIEF.md
# Tagged Descriptor-Chain Fetch DMA

This block walks a linked list of memory descriptors and turns each one into a stream of 32-bit words for downstream processing engines. Software hands it the word address of the first descriptor and a one-cycle start pulse. The block reads the four descriptor words through a simple ready/valid read port. It then fetches the data block one word at a time and presents each word on a ready/valid output. Every word carries routing sidebands decoded from the descriptor's tag.

The sidebands are: target engine, configuration-or-data path, data type, register offset and a last marker. Byte enables trim the final word of a block. A realign flag in the length word widens that final word to a full word instead. A next pointer equal to 1 ends the chain, and a single-cycle done pulse marks the end.

Top module: `tagged_fetch_dma`

## Requirements
- R1: After reset, rd_valid, out_valid and done are all low.
- R2: A descriptor at word address W is read as four requests to W, W+1, W+2, W+3, in that order. The four responses are taken as: data byte address, next-descriptor byte address, length word, tag word.
- R3: A block of L bytes is sent as ceil(L/4) output words, fetched from consecutive word addresses starting at the data byte address divided by 4. Each output word equals the memory word that was read.
- R4: L is length-word bits [27:0]; every other bit of the length word is ignored when counting. Every word except the last has out_keep = 4'hF. The last word has the low (L mod 4) keep bits set, where bit 0 is the lowest-addressed byte, or 4'hF when L mod 4 is 0.
- R5: When length-word bit 29 is set, the last word of the block has out_keep = 4'hF.
- R6: On every word, out_engine = tag[3:0], out_cfg = tag[4], out_dtype = tag[7:6] and out_offset = tag[15:8].
- R7: out_last equals tag[5] on the final word of a block and is 0 on all other words.
- R8: A next-descriptor address of exactly 1 ends the chain. Any other value makes the block fetch the descriptor at that byte address divided by 4, after finishing the current block.
- R9: A descriptor with L = 0 produces no data reads and no output words; the block goes straight on to the next descriptor or to done.
- R10: While out_valid is high and out_ready is low, the output word and its sidebands stay unchanged. While rd_valid is high and rd_ready is low, rd_addr stays unchanged. No word is lost or repeated.
- R11: done is high for exactly one cycle, in the cycle right after the final output word of the chain is accepted. It never coincides with out_valid or rd_valid.
- R12: A start pulse while a chain is in progress is ignored, and the block goes idle once its chain has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a chain |
| first_desc_word | input | ADDR_W-2 | Word address of the first descriptor |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Memory accepts the request |
| rd_addr | output | ADDR_W-2 | Word address of the read |
| rsp_valid | input | 1 | Read data valid (one per accepted request) |
| rsp_data | input | 32 | Read data |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Output word |
| out_keep | output | 4 | Byte enables of the output word |
| out_engine | output | 4 | Target engine code |
| out_cfg | output | 1 | 1 = configuration path, 0 = data path |
| out_dtype | output | 2 | Data type code |
| out_offset | output | 8 | Register offset for configuration writes |
| out_last | output | 1 | Last marker on the final word of a block |
| done | output | 1 | Chain finished pulse |

## Verification
Each read response is consumed on the edge where rsp_valid is high, so an output word appears one cycle after its data response. done rises in the cycle after the final output handshake. The bench stamps every output handshake and every done observation with a shared cycle count, and checks that the done stamp is exactly one past the last handshake stamp. It logs every read request at its handshake, so the descriptor order, the next-pointer jumps and the absence of data reads for empty blocks are all checked from the address sequence rather than from waveform timing. Ready lines toggle in set patterns on both sides, so that the stall behaviour of R10 shows up as an exact word list with no gaps or duplicates.

// File: rtl/fdma_pkg.sv
// Shared types and constants for the tagged descriptor-chain fetch DMA.
// Assumes 32-bit memory words and 4-byte-aligned descriptors and data blocks.
package fdma_pkg;
    localparam int WORD_W      = 32;
    localparam int KEEP_W      = WORD_W / 8;
    localparam int LEN_BITS    = 28;
    localparam int REALIGN_POS = 29;
    localparam logic [WORD_W-1:0] CHAIN_END = 32'h1;

    // Routing sidebands decoded from a descriptor tag
    typedef struct packed {
        logic [3:0] engine;
        logic       cfg;
        logic       last_req;
        logic [1:0] dtype;
        logic [7:0] offset;
    } route_t;

    typedef enum logic [2:0] {
        S_IDLE, S_DREQ, S_DRSP, S_BREQ, S_BRSP, S_EMIT, S_DONE
    } state_t;
endpackage

// File: rtl/fdma_tag_decode.sv
// Splits the low 16 bits of a descriptor tag into routing sidebands.
// Purely combinational; assumes the tag is held stable by the caller.
module fdma_tag_decode
    import fdma_pkg::*;
(
    input  logic [15:0] tag,
    output route_t      route
);
    // Field extraction at fixed tag bit positions
    always_comb begin
        route.engine   = tag[3:0];
        route.cfg      = tag[4];
        route.last_req = tag[5];
        route.dtype    = tag[7:6];
        route.offset   = tag[15:8];
    end
endmodule

// File: rtl/fdma_beat_calc.sv
// From the bytes still to send, works out the byte enables of the current
// word and whether it is the block's final word. Assumes remaining > 0.
module fdma_beat_calc #(
    parameter int CNT_W  = 28,
    parameter int KEEP_W = 4
) (
    input  logic [CNT_W-1:0]  remaining,
    input  logic              realign,
    output logic [KEEP_W-1:0] keep,
    output logic              final_beat
);
    // One enable per byte lane: lane b is valid if more than b bytes remain
    for (genvar b = 0; b < KEEP_W; b++) begin : g_lane
        assign keep[b] = realign || (remaining > CNT_W'(b));
    end

    // Final word when no more than one word of bytes is left
    assign final_beat = (remaining <= CNT_W'(KEEP_W));
endmodule

// File: rtl/tagged_fetch_dma.sv
// Fetch-direction descriptor-chain DMA. Reads 4-word descriptors, streams
// each data block as tagged words and follows next pointers until the value
// 1. Assumes one outstanding read, with exactly one rsp_valid per accepted
// request, arriving at least one cycle after acceptance.
module tagged_fetch_dma
    import fdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-3:0] first_desc_word,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-3:0] rd_addr,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [KEEP_W-1:0] out_keep,
    output logic [3:0]        out_engine,
    output logic              out_cfg,
    output logic [1:0]        out_dtype,
    output logic [7:0]        out_offset,
    output logic              out_last,
    output logic              done
);
    localparam int WA_W = ADDR_W - 2;

    state_t              state;
    logic [1:0]          widx;
    logic [WA_W-1:0]     desc_ptr;
    logic [WA_W-1:0]     data_ptr;
    logic [WORD_W-1:0]   next_q;
    logic [LEN_BITS-1:0] remaining;
    logic                realign_q;
    logic [15:0]         tag_q;
    logic [WORD_W-1:0]   word_q;
    route_t              route;
    logic                final_beat;
    logic [KEEP_W-1:0]   keep_c;

    fdma_tag_decode u_dec (.tag(tag_q), .route(route));

    fdma_beat_calc #(.CNT_W(LEN_BITS), .KEEP_W(KEEP_W)) u_beat (
        .remaining (remaining),
        .realign   (realign_q),
        .keep      (keep_c),
        .final_beat(final_beat)
    );

    // Main sequencer: descriptor fetch, data fetch, emission, chain walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            widx      <= '0;
            desc_ptr  <= '0;
            data_ptr  <= '0;
            next_q    <= '0;
            remaining <= '0;
            realign_q <= 1'b0;
            tag_q     <= '0;
            word_q    <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    desc_ptr <= first_desc_word;
                    widx     <= '0;
                    state    <= S_DREQ;
                end
                S_DREQ: if (rd_ready) state <= S_DRSP;
                S_DRSP: if (rsp_valid) begin
                    case (widx)
                        2'd0: data_ptr <= rsp_data[ADDR_W-1:2];
                        2'd1: next_q   <= rsp_data;
                        2'd2: begin
                            remaining <= rsp_data[LEN_BITS-1:0];
                            realign_q <= rsp_data[REALIGN_POS];
                        end
                        default: tag_q <= rsp_data[15:0];
                    endcase
                    if (widx != 2'd3) begin
                        widx  <= widx + 2'd1;
                        state <= S_DREQ;
                    end else if (remaining != '0) begin
                        state <= S_BREQ;
                    end else if (next_q == CHAIN_END) begin
                        state <= S_DONE;
                    end else begin
                        desc_ptr <= next_q[ADDR_W-1:2];
                        widx     <= '0;
                        state    <= S_DREQ;
                    end
                end
                S_BREQ: if (rd_ready) state <= S_BRSP;
                S_BRSP: if (rsp_valid) begin
                    word_q <= rsp_data;
                    state  <= S_EMIT;
                end
                S_EMIT: if (out_ready) begin
                    if (!final_beat) begin
                        remaining <= remaining - LEN_BITS'(KEEP_W);
                        data_ptr  <= data_ptr + WA_W'(1);
                        state     <= S_BREQ;
                    end else if (next_q == CHAIN_END) begin
                        state <= S_DONE;
                    end else begin
                        desc_ptr <= next_q[ADDR_W-1:2];
                        widx     <= '0;
                        state    <= S_DREQ;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Read request port: descriptor word or data word address
    always_comb begin
        rd_valid = (state == S_DREQ) || (state == S_BREQ);
        rd_addr  = (state == S_DREQ) ? desc_ptr + WA_W'(widx) : data_ptr;
    end

    // Output word and sidebands
    always_comb begin
        out_valid  = (state == S_EMIT);
        out_data   = word_q;
        out_keep   = keep_c;
        out_engine = route.engine;
        out_cfg    = route.cfg;
        out_dtype  = route.dtype;
        out_offset = route.offset;
        out_last   = out_valid && final_beat && route.last_req;
        done       = (state == S_DONE);
    end
endmodule

// File: rtl/tagged_fetch_dma_checker.sv
// Protocol and timing properties for tagged_fetch_dma, bound to every instance.
module tagged_fetch_dma_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [ADDR_W-3:0] rd_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [31:0]       out_data,
    input logic [3:0]        out_keep,
    input logic              out_last,
    input logic              done
);
    // R10: a stalled output word is held unchanged
    a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_keep) && $stable(out_last));

    // R10: a stalled read request keeps its address
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    // R4: byte enables are always a contiguous run from lane 0
    a_r4_keep_shape: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_keep == 4'h1 || out_keep == 4'h3
                       || out_keep == 4'h7 || out_keep == 4'hF));

    // R4: a partial word is a block's last, so no word follows it at once
    a_r4_partial_ends: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_keep != 4'hF |=> !out_valid);

    // R7: the last marker only appears on a presented word
    a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: done never overlaps traffic
    a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid && !rd_valid);
endmodule

bind tagged_fetch_dma tagged_fetch_dma_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_addr  (rd_addr),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_keep (out_keep),
    .out_last (out_last),
    .done     (done)
);

// File: tb/test_tagged_fetch_dma.sv
module test_tagged_fetch_dma;
    localparam int ADDR_W = 32;
    localparam int WA_W   = ADDR_W - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [WA_W-1:0] first_desc_word = '0;
    logic rd_valid, rd_ready = 1'b0;
    logic [WA_W-1:0] rd_addr;
    logic rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic out_valid, out_ready = 1'b0;
    logic [31:0] out_data;
    logic [3:0] out_keep, out_engine;
    logic out_cfg, out_last, done;
    logic [1:0] out_dtype;
    logic [7:0] out_offset;

    always #2 clk = ~clk;  // 250 MHz

    tagged_fetch_dma #(.ADDR_W(ADDR_W)) i_tagged_fetch_dma (
        .clk(clk), .rst_n(rst_n), .start(start), .first_desc_word(first_desc_word),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_keep(out_keep), .out_engine(out_engine), .out_cfg(out_cfg),
        .out_dtype(out_dtype), .out_offset(out_offset), .out_last(out_last),
        .done(done)
    );

    int total = 0, bad = 0;
    int cyc = 0, mode = 0;
    logic [31:0] mem [0:255];
    logic [31:0] cap_data [0:63];
    logic [3:0]  cap_keep [0:63];
    logic [14:0] cap_route [0:63];
    logic        cap_last [0:63];
    int ncap = 0, nrd = 0, done_cnt = 0, acc_cyc = 0, done_cyc = 0;
    logic [WA_W-1:0] rdlog [0:63];

    // Vector table: length word, tag word, stall mode
    localparam logic [31:0] VLEN [5] = '{32'd8, 32'd7, 32'h2000_0005, 32'h4000_0001, 32'd3};
    localparam logic [31:0] VTAG [5] = '{32'h01, 32'h23, 32'h2871, 32'hCF, 32'h2F};
    localparam int          VMOD [5] = '{0, 1, 1, 0, 1};

    function automatic logic [31:0] dval(input int i);
        return 32'h9E37_79B9 * (i + 1);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: one response per accepted request, one cycle later
    initial forever begin
        @(posedge clk);
        rsp_valid <= 1'b0;
        if (rd_valid && rd_ready) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mem[rd_addr[7:0]];
            if (nrd < 64) rdlog[nrd] <= rd_addr;
            nrd <= nrd + 1;
        end
        rd_ready <= (mode == 0) ? 1'b1 : (cyc % 2 == 0);
    end

    // Output sink and done observer
    initial forever begin
        @(posedge clk);
        if (out_valid && out_ready) begin
            if (ncap < 64) begin
                cap_data[ncap]  <= out_data;
                cap_keep[ncap]  <= out_keep;
                cap_route[ncap] <= {out_engine, out_cfg, out_dtype, out_offset};
                cap_last[ncap]  <= out_last;
            end
            ncap    <= ncap + 1;
            acc_cyc <= cyc;
        end
        if (done) begin
            done_cnt <= done_cnt + 1;
            done_cyc <= cyc;
        end
        out_ready <= (mode == 0) ? 1'b1 : (cyc % 3 != 1);
        cyc <= cyc + 1;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic pulse_start(input logic [WA_W-1:0] w);
        @(negedge clk);
        start = 1'b1;
        first_desc_word = w;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        int d0 = done_cnt;
        while (done_cnt == d0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(req, 64'(done_cnt - d0), 64'd1);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_desc(input int w, input logic [31:0] a, input logic [31:0] n,
                            input logic [31:0] l, input logic [31:0] g);
        mem[w] = a; mem[w+1] = n; mem[w+2] = l; mem[w+3] = g;
    endtask

    // Check one captured word against values derived from a descriptor
    task automatic chk_beat(input int k, input int dw, input int i, input int n,
                            input logic [31:0] lw, input logic [31:0] tg);
        int L = int'(lw[27:0]);
        logic [3:0] ek;
        ek = (i != n - 1 || lw[29] || L % 4 == 0) ? 4'hF : 4'((1 << (L % 4)) - 1);
        chk("R3 data", 64'(cap_data[k]), 64'(dval(dw + i)));
        chk(lw[29] ? "R5 keep" : "R4 keep", 64'(cap_keep[k]), 64'(ek));
        chk("R6 route", 64'(cap_route[k]), 64'({tg[3:0], tg[4], tg[7:6], tg[15:8]}));
        chk("R7 last", 64'(cap_last[k]), 64'((i == n - 1) && tg[5]));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = dval(i);
        repeat (3) @(negedge clk);
        // R1: idle state under reset and just after
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 done", 64'(done), 64'd0);

        // Table walk: single-descriptor chains
        for (int v = 0; v < 5; v++) begin
            int n;
            mode = VMOD[v];
            set_desc(16, 32'h100, 32'h1, VLEN[v], VTAG[v]);
            n = (int'(VLEN[v][27:0]) + 3) / 4;
            ncap = 0; nrd = 0;
            pulse_start(WA_W'(16));
            wait_done("R11 done seen");
            chk("R3 word count", 64'(ncap), 64'(n));
            for (int i = 0; i < n; i++) chk_beat(i, 64, i, n, VLEN[v], VTAG[v]);
            for (int i = 0; i < 4; i++) chk("R2 desc order", 64'(rdlog[i]), 64'(16 + i));
            chk("R11 done timing", 64'(done_cyc), 64'(acc_cyc + 1));
        end

        // Chain of three: second is empty (R8, R9)
        mode = 1;
        set_desc(16, 32'h100, 32'h80, 32'd6, 32'h03);
        set_desc(32, 32'h180, 32'h90, 32'd0, 32'h01);
        set_desc(36, 32'h140, 32'h1,  32'd4, 32'h21);
        ncap = 0; nrd = 0;
        pulse_start(WA_W'(16));
        wait_done("R8 chain done");
        chk("R8 word count", 64'(ncap), 64'd3);
        chk_beat(0, 64, 0, 2, 32'd6, 32'h03);
        chk_beat(1, 64, 1, 2, 32'd6, 32'h03);
        chk_beat(2, 80, 0, 1, 32'd4, 32'h21);
        chk("R8 next followed", 64'(rdlog[6]), 64'd32);
        chk("R9 empty skipped", 64'(rdlog[10]), 64'd36);
        chk("R9 read count", 64'(nrd), 64'd15);
        chk("R11 chain done timing", 64'(done_cyc), 64'(acc_cyc + 1));

        // Lone empty descriptor (R9)
        mode = 0;
        set_desc(16, 32'h100, 32'h1, 32'd0, 32'h01);
        ncap = 0; nrd = 0;
        pulse_start(WA_W'(16));
        wait_done("R9 empty done");
        chk("R9 no words", 64'(ncap), 64'd0);
        chk("R9 only desc reads", 64'(nrd), 64'd4);

        // Start while busy is ignored (R12)
        mode = 1;
        set_desc(16, 32'h100, 32'h1, 32'd24, 32'h03);
        set_desc(40, 32'h200, 32'h1, 32'd4, 32'h01);
        ncap = 0; nrd = 0;
        pulse_start(WA_W'(16));
        repeat (10) @(negedge clk);
        pulse_start(WA_W'(40));
        wait_done("R12 done");
        chk("R12 word count", 64'(ncap), 64'd6);
        for (int i = 0; i < 6; i++) chk_beat(i, 64, i, 6, 32'd24, 32'h03);
        repeat (20) @(negedge clk);
        chk("R12 idle after", 64'(nrd), 64'd10);
        chk("R12 no extra done", 64'(out_valid), 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule